// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the slave side of a two-wire (I2C) serial memory of up to 2048 bytes. The bytes are held in an internal register array. A system clock oversamples SCL and SDA. The block drives SDA only by pulling it low through an output enable, and the pad or the board supplies the pull-up. A master on the bus selects the device with a four-bit type code. It then writes single bytes or bursts of up to one page, or reads from a random address, from the current address, or sequentially.

Written bytes are first collected in a page buffer. They reach the array only after the STOP that closes the write, over an internal write cycle whose length is a parameter in clock ticks. While that cycle runs the device does not answer the bus. A master finds out that the cycle has finished by repeatedly sending an address byte until it gets an acknowledge. An address pointer keeps track of the last accessed location, so a read that gives no word address continues from that point.

Top module: `serial_nvm_slave`

## Requirements
- R1: After reset `sda_oe` is low, and every array location reads back as the erased value 0xFF.
- R2: The slave acknowledges an address byte only when its bits 7:4 equal 1010, by holding `sda_oe` high through the ninth SCL clock. On a mismatch it gives no acknowledge and ignores every following byte until the next START.
- R3: In the address byte, bits 3:1 carry the upper memory address bits, with bit 3 as the most significant. Bit 0 selects read (1) or write (0). In a write, the next byte is the low eight address bits, and each data byte after it is acknowledged and stored at that address.
- R4: The internal write cycle starts only at the STOP that ends a write carrying at least one data byte, and it lasts WRITE_TICKS clocks. A STOP that follows the word address and no data byte starts no cycle and leaves the array unchanged.
- R5: Within one write, successive data bytes go to addresses whose low four bits increment while the upper bits stay fixed. Byte 17 and later wrap to the start of the same 16-byte page and overwrite earlier bytes. Locations outside that page are untouched.
- R6: While the write cycle runs, START conditions are ignored and no acknowledge is given. Once the cycle completes, an address byte with the write bit is acknowledged again.
- R7: A read that gives no word address returns the byte at the last accessed address plus one.
- R8: During a read, each acknowledge from the master makes the slave send the byte at the next address. The full address increments, crossing page and upper-bit boundaries, and wraps from 0x7FF to 0x000.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START or STOP.
- R10: `sda_oe` changes only after a falling SCL edge, for both acknowledge and read data. Data is sent most significant bit first.
- R11: A repeated START at any point restarts address-byte reception. A word address written before it sets the read address of the read that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired level) |
| sda_oe | output | 1 | High pulls SDA low; low releases it |

## Verification
Two events can land on neighbouring cycles. One is the STOP that closes a write and starts the internal write cycle. The other is the START of a master that polls for an acknowledge straight after that STOP. The bench provokes this by sending a poll as soon as every written transfer ends. It requires the poll to go unacknowledged, and requires an identical poll after the cycle has elapsed to be acknowledged. A second overlap is the SCL falling edge that ends an acknowledge: on that same edge the next read byte is loaded and the pointer advances. This is judged by comparing the bytes of sequential reads against an independent model, both across the 0x0FF to 0x100 boundary and across the wrap from the top of the array.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_WADR,
      ST_WADR_ACK,
      ST_WDAT,
      ST_WDAT_ACK,
      ST_TX,
      ST_MACK,
      ST_HOLD
   } nvm_state_t;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned ID_W   = 4;
endpackage

// File: rtl/nvm_bus_sync.sv
module nvm_bus_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_sh;
   logic [STAGES-1:0] sda_sh;
   logic              scl_d;
   logic              sda_d;
   logic              scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         scl_d  <= scl_sh[STAGES-1];
         sda_d  <= sda_sh[STAGES-1];
      end
   end

   assign scl_s     = scl_sh[STAGES-1];
   assign sda       = sda_sh[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda;
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
   parameter int unsigned ADDR_W      = 11,
   parameter int unsigned PAGE_W      = 4,
   parameter int unsigned WRITE_TICKS = 400,
   parameter logic [7:0]  ERASED      = 8'hFF
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     buf_clr,
   input  logic                     buf_we,
   input  logic [PAGE_W-1:0]        buf_idx,
   input  logic [7:0]               buf_data,
   input  logic [ADDR_W-PAGE_W-1:0] page_sel,
   input  logic                     commit,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [7:0]               rd_data,
   output logic                     busy
);
   localparam int unsigned DEPTH      = 1 << ADDR_W;
   localparam int unsigned PAGE_BYTES = 1 << PAGE_W;
   localparam int unsigned CNT_W      = $clog2(WRITE_TICKS + 1);
   localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(WRITE_TICKS - 1);
   localparam logic [CNT_W-1:0] COPY_END  = CNT_W'(PAGE_BYTES);

   logic [7:0]               mem  [DEPTH];
   logic [7:0]               pbuf [PAGE_BYTES];
   logic [PAGE_BYTES-1:0]    pval;
   logic [ADDR_W-PAGE_W-1:0] page_q;
   logic [CNT_W-1:0]         tick;
   logic [PAGE_W-1:0]        copy_idx;
   logic                     copy_en;

   assign copy_idx = tick[PAGE_W-1:0];
   assign copy_en  = busy && (tick < COPY_END) && pval[copy_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         tick   <= '0;
         pval   <= '0;
         page_q <= '0;
      end else if (busy) begin
         tick <= tick + 1'b1;
         if (tick == LAST_TICK) begin
            busy <= 1'b0;
            pval <= '0;
         end
      end else if (commit && (|pval)) begin
         busy <= 1'b1;
         tick <= '0;
      end else if (buf_clr) begin
         pval <= '0;
      end else if (buf_we) begin
         pval[buf_idx] <= 1'b1;
         page_q        <= page_sel;
      end
   end

   always_ff @(posedge clk) begin
      if (buf_we && !busy) pbuf[buf_idx] <= buf_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
      end else if (copy_en) begin
         mem[{page_q, copy_idx}] <= pbuf[copy_idx];
      end
   end

   assign rd_data = mem[rd_addr];

   // R5: the page buffer is never filled while its contents are being copied
   assert_no_fill_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !buf_we);
endmodule

// File: rtl/nvm_protocol.sv
module nvm_protocol
   import nvm_pkg::*;
#(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned PAGE_W = 4,
   parameter logic [3:0]  DEV_ID = 4'b1010
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sda,
   input  logic                     scl_rise,
   input  logic                     scl_fall,
   input  logic                     start_det,
   input  logic                     stop_det,
   input  logic                     busy,
   input  logic [7:0]               rd_data,
   output logic                     sda_oe,
   output logic                     buf_clr,
   output logic                     buf_we,
   output logic [PAGE_W-1:0]        buf_idx,
   output logic [7:0]               buf_data,
   output logic [ADDR_W-PAGE_W-1:0] page_sel,
   output logic                     commit,
   output logic [ADDR_W-1:0]        rd_addr
);
   localparam int unsigned HI_W = ADDR_W - 8;

   nvm_state_t        state;
   logic [3:0]        cnt;
   logic [7:0]        shreg;
   logic [HI_W-1:0]   hi_q;
   logic [ADDR_W-1:0] ptr;
   logic [PAGE_W-1:0] widx;
   logic [PAGE_W-1:0] widx_nxt;
   logic              is_read;
   logic              mack;
   logic              start_ok;
   logic              rx_state;
   logic              rx_done;

   assign start_ok = start_det & ~busy;
   assign rx_state = (state == ST_DEV) || (state == ST_WADR) || (state == ST_WDAT);
   assign rx_done  = rx_state && scl_fall && (cnt == 4'd8);
   assign widx_nxt = widx + 1'b1;

   assign buf_clr  = start_ok;
   assign commit   = stop_det & ~busy;
   assign buf_we   = (state == ST_WDAT) && rx_done;
   assign buf_idx  = widx;
   assign buf_data = shreg;
   assign page_sel = ptr[ADDR_W-1:PAGE_W];
   assign rd_addr  = ptr;

   always_comb begin
      unique case (state)
         ST_DEV_ACK, ST_WADR_ACK, ST_WDAT_ACK: sda_oe = 1'b1;
         ST_TX:                                sda_oe = ~shreg[7];
         default:                              sda_oe = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         shreg   <= '0;
         hi_q    <= '0;
         ptr     <= '0;
         widx    <= '0;
         is_read <= 1'b0;
         mack    <= 1'b0;
      end else if (stop_det) begin
         state <= ST_IDLE;
      end else if (start_ok) begin
         state <= ST_DEV;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_IDLE, ST_HOLD: ;
            ST_DEV, ST_WADR, ST_WDAT: begin
               if (scl_rise && cnt < 4'd8) begin
                  shreg <= {shreg[6:0], sda};
                  cnt   <= cnt + 1'b1;
               end else if (rx_done) begin
                  if (state == ST_DEV) begin
                     if (shreg[7:4] == DEV_ID) begin
                        state   <= ST_DEV_ACK;
                        is_read <= shreg[0];
                        hi_q    <= shreg[HI_W:1];
                     end else begin
                        state <= ST_HOLD;
                     end
                  end else if (state == ST_WADR) begin
                     ptr   <= {hi_q, shreg};
                     state <= ST_WADR_ACK;
                  end else begin
                     widx  <= widx_nxt;
                     ptr   <= {ptr[ADDR_W-1:PAGE_W], widx_nxt};
                     state <= ST_WDAT_ACK;
                  end
               end
            end
            ST_DEV_ACK: if (scl_fall) begin
               cnt <= '0;
               if (is_read) begin
                  shreg <= rd_data;
                  ptr   <= ptr + 1'b1;
                  state <= ST_TX;
               end else begin
                  state <= ST_WADR;
               end
            end
            ST_WADR_ACK: if (scl_fall) begin
               cnt   <= '0;
               widx  <= ptr[PAGE_W-1:0];
               state <= ST_WDAT;
            end
            ST_WDAT_ACK: if (scl_fall) begin
               cnt   <= '0;
               state <= ST_WDAT;
            end
            ST_TX: if (scl_fall) begin
               shreg <= {shreg[6:0], 1'b1};
               cnt   <= cnt + 1'b1;
               if (cnt == 4'd7) state <= ST_MACK;
            end
            ST_MACK: begin
               if (scl_rise) mack <= ~sda;
               if (scl_fall) begin
                  if (mack) begin
                     shreg <= rd_data;
                     ptr   <= ptr + 1'b1;
                     cnt   <= '0;
                     state <= ST_TX;
                  end else begin
                     state <= ST_HOLD;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R10: the output enable moves only after a falling clock edge or a bus condition
   assert_oe_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> ($past(scl_fall) || $past(stop_det) || $past(start_det)));

   // R6: a START seen during the write cycle leaves the controller idle
   assert_start_ignored_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_det && state == ST_IDLE) |=> (state == ST_IDLE));

   // R4: the write cycle is only ever launched by a STOP
   assert_cycle_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_det));
endmodule

// File: rtl/serial_nvm_slave.sv
module serial_nvm_slave #(
   parameter int unsigned MEM_BYTES   = 2048,
   parameter int unsigned PAGE_BYTES  = 16,
   parameter int unsigned WRITE_TICKS = 400,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [3:0]  DEV_ID      = 4'b1010,
   parameter logic [7:0]  ERASED      = 8'hFF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe
);
   localparam int unsigned ADDR_W = $clog2(MEM_BYTES);
   localparam int unsigned PAGE_W = $clog2(PAGE_BYTES);

   if (MEM_BYTES != (1 << ADDR_W) || ADDR_W < 9 || ADDR_W > 11) begin : g_bad_mem
      $error("MEM_BYTES must be a power of two from 512 to 2048");
   end
   if (PAGE_BYTES != (1 << PAGE_W) || PAGE_W < 1 || PAGE_W > 8) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two from 2 to 256");
   end
   if (WRITE_TICKS <= PAGE_BYTES) begin : g_bad_ticks
      $error("WRITE_TICKS must exceed PAGE_BYTES");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic                     sda_s;
   logic                     scl_rise;
   logic                     scl_fall;
   logic                     start_det;
   logic                     stop_det;
   logic                     busy;
   logic [7:0]               rd_data;
   logic                     buf_clr;
   logic                     buf_we;
   logic [PAGE_W-1:0]        buf_idx;
   logic [7:0]               buf_data;
   logic [ADDR_W-PAGE_W-1:0] page_sel;
   logic                     commit;
   logic [ADDR_W-1:0]        rd_addr;

   nvm_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda       (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   nvm_protocol #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEV_ID(DEV_ID)) u_proto (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda       (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .busy      (busy),
      .rd_data   (rd_data),
      .sda_oe    (sda_oe),
      .buf_clr   (buf_clr),
      .buf_we    (buf_we),
      .buf_idx   (buf_idx),
      .buf_data  (buf_data),
      .page_sel  (page_sel),
      .commit    (commit),
      .rd_addr   (rd_addr)
   );

   nvm_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_TICKS(WRITE_TICKS), .ERASED(ERASED)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .buf_clr  (buf_clr),
      .buf_we   (buf_we),
      .buf_idx  (buf_idx),
      .buf_data (buf_data),
      .page_sel (page_sel),
      .commit   (commit),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .busy     (busy)
   );

   // R6: the bus is left alone for the whole internal write cycle
   assert_silent_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe);
endmodule

// File: tb/sim_serial_nvm_slave.sv
module sim_serial_nvm_slave;
   localparam int WT = 400;
   localparam int Q  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_oe;
   logic sda_line;
   int   n_chk = 0;
   int   n_err = 0;
   logic [7:0] pg [0:17];
   logic [7:0] rb [0:15];

   // address (11 bits) and data (8 bits) per vector
   localparam logic [18:0] VEC [0:5] = '{
      {11'h000, 8'h5A}, {11'h0FF, 8'hC3}, {11'h100, 8'h11},
      {11'h3A7, 8'h9E}, {11'h5F0, 8'h00}, {11'h7FF, 8'hE7}
   };

   always #5 clk = ~clk;

   assign sda_line = m_sda & ~sda_oe;

   serial_nvm_slave #(.WRITE_TICKS(WT)) u0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (m_scl),
      .sda_i  (sda_line),
      .sda_oe (sda_oe)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_start;
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop;
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b1; tick(2 * Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; tick(Q);
         m_scl = 1'b1; tick(2 * Q);
         m_scl = 1'b0; tick(Q);
      end
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      ack = ~sda_line; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         m_scl = 1'b1; tick(Q);
         b[i] = sda_line; tick(Q);
         m_scl = 1'b0;
      end
      tick(Q);
      m_sda = ~give_ack; tick(Q);
      m_scl = 1'b1; tick(2 * Q);
      m_scl = 1'b0; tick(Q);
      m_sda = 1'b1;
   endtask

   // write n bytes of pg[] starting at address a
   task automatic nvm_write(input logic [10:0] a, input int n, input string tag);
      logic ack;
      bus_start;
      send_byte({4'b1010, a[10:8], 1'b0}, ack);
      check({tag, " address ack"}, ack, 1);
      send_byte(a[7:0], ack);
      check({tag, " word ack"}, ack, 1);
      for (int i = 0; i < n; i++) begin
         send_byte(pg[i], ack);
         if (i < 2 || i == n - 1) check({tag, " data ack"}, ack, 1);
      end
      bus_stop;
   endtask

   task automatic poll(output logic ack);
      bus_start;
      send_byte(8'hA0, ack);
      bus_stop;
   endtask

   // read n bytes into rb[], random (word address first) or current
   task automatic nvm_read(input logic [10:0] a, input logic rnd, input int n, input string tag);
      logic ack;
      bus_start;
      if (rnd) begin
         send_byte({4'b1010, a[10:8], 1'b0}, ack);
         check({tag, " address ack"}, ack, 1);
         send_byte(a[7:0], ack);
         check({tag, " word ack"}, ack, 1);
         bus_start;
      end
      send_byte({4'b1010, a[10:8], 1'b1}, ack);
      check({tag, " read address ack"}, ack, 1);
      for (int i = 0; i < n; i++) recv_byte(i < n - 1, rb[i]);
      bus_stop;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic ack;
      logic [7:0] b;
      tick(10);
      check("R1 sda_oe in reset", sda_oe, 0);
      rst_n = 1'b1;
      tick(10);
      check("R1 sda_oe after reset", sda_oe, 0);
      nvm_read(11'h234, 1'b1, 1, "R1");
      check("R1 erased value", rb[0], 8'hFF);

      // vector table: byte write, poll during cycle, poll after, random read back
      for (int v = 0; v < 6; v++) begin
         pg[0] = VEC[v][7:0];
         nvm_write(VEC[v][18:8], 1, "R3");
         poll(ack);
         check("R6 poll while busy", ack, 0);
         tick(WT + 20);
         poll(ack);
         check("R6 poll after cycle", ack, 1);
         nvm_read(VEC[v][18:8], 1'b1, 1, "R11");
         check("R3 R11 read back (R10 bit order)", rb[0], VEC[v][7:0]);
      end

      // R7: pointer wrapped past 0x7FF after last read, current read gives 0x000
      nvm_read(11'h000, 1'b0, 1, "R7");
      check("R7 current address read", rb[0], 8'h5A);
      nvm_read(11'h000, 1'b0, 1, "R7");
      check("R7 next current read", rb[0], 8'hFF);

      // R8: sequential across 0x0FF/0x100 and across array end
      nvm_read(11'h0FF, 1'b1, 2, "R8");
      check("R8 first of boundary pair", rb[0], 8'hC3);
      check("R8 crosses into 0x100", rb[1], 8'h11);
      nvm_read(11'h7FF, 1'b1, 2, "R8");
      check("R8 top byte", rb[0], 8'hE7);
      check("R8 wrap to 0x000", rb[1], 8'h5A);

      // R2: wrong device type, then a further byte is ignored
      bus_start;
      send_byte(8'hB0, ack);
      check("R2 mismatched type no ack", ack, 0);
      send_byte(8'h12, ack);
      check("R2 following byte ignored", ack, 0);
      bus_stop;
      poll(ack);
      check("R2 no write cycle from ignored bytes", ack, 1);

      // R4: STOP after word address only
      bus_start;
      send_byte(8'hA6, ack);
      send_byte(8'hA7, ack);
      bus_stop;
      poll(ack);
      check("R4 no cycle without data", ack, 1);
      nvm_read(11'h3A7, 1'b1, 1, "R4");
      check("R4 array unchanged", rb[0], 8'h9E);

      // R5: 18-byte page write from 0x23E wraps inside page 0x230
      for (int i = 0; i < 18; i++) pg[i] = 8'(8'h40 + i);
      nvm_write(11'h23E, 18, "R5");
      poll(ack);
      check("R5 R4 busy after page write", ack, 0);
      tick(WT + 20);
      nvm_read(11'h230, 1'b1, 16, "R5");
      for (int k = 0; k < 16; k++) begin
         int e;
         e = (k < 14) ? 8'h42 + k : (k == 14 ? 8'h50 : 8'h51);
         check($sformatf("R5 page byte %0d", k), rb[k], e);
      end
      nvm_read(11'h240, 1'b1, 1, "R5");
      check("R5 next page untouched", rb[0], 8'hFF);
      nvm_read(11'h22F, 1'b1, 1, "R5");
      check("R5 previous page untouched", rb[0], 8'hFF);

      // R9: after a master NACK the slave keeps SDA released
      bus_start;
      send_byte(8'hA1, ack);
      check("R9 read address ack", ack, 1);
      recv_byte(1'b0, b);
      recv_byte(1'b0, b);
      check("R9 released after nack", b, 8'hFF);
      check("R9 sda_oe low", sda_oe, 0);
      bus_stop;

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule